// File: doc/BRIEF.md
# Dithered Duty-Cycle Bus Bit Encoder

This block turns a parallel data word into a serial frame on one logic-level bus drive line. Each bit opens with a low phase, and the length of that low phase carries the bit's value: a short low phase means one and a long low phase means zero. The line rests high between frames. The caller presents a word, a frame length and a deviation select, then pulses a start strobe. The block reports that it is busy until the frame ends, and it raises a one-clock done pulse after the final bit.

To lower the peak of emitted energy, the block lengthens or shortens each bit period by a small pseudo-random amount around a nominal 30 reference clocks. A free-running 16-bit maximal-length shift register supplies the offset. The deviation select sets how far the period may move, or holds it fixed. The period never drops below 27 clocks, which keeps the bit rate at or below the bus limit when the reference clock runs at 4 MHz. Each bit's low-phase length is rounded from that bit's own period.

Top module: `pwm_bus_encoder`

## Requirements
- R1: While reset is asserted, and in the first cycle after release, `bus_o` is 1, `busy_o` is 0 and `done_o` is 0. Asserting reset in the middle of a frame returns the line high at once.
- R2: A zero bit with period P holds the line low for floor((2P+1)/3) clocks, which is the nearest integer to 2P/3, and then high for the rest of the P clocks.
- R3: A one bit with period P holds the line low for floor((P+1)/3) clocks, which is the nearest integer to P/3, and then high for the rest of the P clocks.
- R4: With `dev_sel_i` at 2'b00 or 2'b11, every bit period is exactly 30 clocks.
- R5: With `dev_sel_i` at 2'b10, every bit period lies between 28 and 32 clocks inclusive.
- R6: With `dev_sel_i` at 2'b01, every bit period lies between 27 and 34 clocks inclusive and never drops below 27. Over a 16-bit or longer frame, the periods take more than one value.
- R7: The frame carries `data_i[L-1]` first and `data_i[0]` last, where L is the effective frame length. The word is captured by the start strobe.
- R8: The effective frame length L equals `frame_len_i` for values 1 to 32. A value of 0 sends 1 bit, and values above 32 send 32 bits.
- R9: A start strobe that arrives while `busy_o` is 1 has no effect on the bits sent, on the frame length, or on the state after done. This includes a strobe in the done cycle.
- R10: `busy_o` rises in the cycle after the start strobe is sampled, and the first bit's low phase begins in that same cycle. `done_o` is high for exactly one clock, right after the high phase of the last bit. After that cycle `busy_o` is 0 and `bus_o` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start_i | input | 1 | Frame start strobe, sampled while idle |
| frame_len_i | input | 6 | Bits per frame, 1 to 32 (0 means 1, above 32 means 32) |
| data_i | input | 32 | Frame word, most significant bit of the frame sent first |
| dev_sel_i | input | 2 | Period deviation: 01 wide, 10 narrow, 00/11 fixed |
| bus_o | output | 1 | Logic-level bus drive, high when idle |
| busy_o | output | 1 | High from frame start through the done cycle |
| done_o | output | 1 | One-clock pulse at the end of a frame |

## Verification
The bench measures the length of every low and high run on the line. From those runs it rebuilds each bit's value and period, so the rounding rule is checked against the period actually produced, whatever offset the shift register gave. Words of all ones, all zeros, alternating bits and mixed nibbles show whether the low phase follows the bit value rather than the bit position. The single-bit, zero-length and over-length frames show whether the length field is decoded correctly. The three deviation settings are each checked against their own period window, which shows whether the select is decoded and the floor is applied. Start strobes injected mid-frame and in the done cycle, carrying a different word, would show up as changed bits or an extra frame if the block accepted them.

// File: rtl/pwm_enc_pkg.sv
package pwm_enc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BIT  = 2'd1,
    ST_DONE = 2'd2
  } enc_state_t;

  localparam logic [1:0] DEV_WIDE   = 2'b01;
  localparam logic [1:0] DEV_NARROW = 2'b10;

endpackage

// File: rtl/pwm_dither_gen.sv
module pwm_dither_gen
  import pwm_enc_pkg::*;
#(
  parameter int               LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAPS  = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED  = 16'hACE1,
  parameter int               PER_W  = 6,
  parameter int               NOM    = 30,
  parameter int               MINP   = 27,
  parameter int               DEV_HI = 4,
  parameter int               DEV_LO = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       dev_sel_i,
  output logic [PER_W-1:0] period_o
);

  logic [LFSR_W-1:0] lfsr_q, lfsr_d;
  logic              lfsr_en;
  int                raw, lim, off, per;

  assign lfsr_en = 1'b1;

  always_comb begin
    lfsr_d = {1'b0, lfsr_q[LFSR_W-1:1]} ^ (lfsr_q[0] ? TAPS : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lfsr_q <= SEED;
    else if (lfsr_en) lfsr_q <= lfsr_d;
  end

  always_comb begin
    raw = int'($signed(lfsr_q[3:0]));
    case (dev_sel_i)
      DEV_WIDE:   lim = DEV_HI;
      DEV_NARROW: lim = DEV_LO;
      default:    lim = 0;
    endcase
    if (raw > lim)       off = lim;
    else if (raw < -lim) off = -lim;
    else                 off = raw;
    per = NOM + off;
    if (per < MINP) per = MINP;
    period_o = PER_W'(per);
  end

  // R6: the shift register must never lock up in the all-zero state
  assert_lfsr_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

  // R6: the offered period stays inside the legal window
  assert_period_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(period_o) >= MINP) && (int'(period_o) <= NOM + DEV_HI));

endmodule

// File: rtl/pwm_phase_lut.sv
module pwm_phase_lut #(
  parameter int PER_W = 6,
  parameter int PMIN  = 26,
  parameter int PMAX  = 34,
  parameter int NOM   = 30
) (
  input  logic [PER_W-1:0] period_i,
  input  logic             bit_i,
  output logic [PER_W-1:0] low_o
);

  localparam int N = PMAX - PMIN + 1;

  logic [PER_W-1:0] tbl_one  [N];
  logic [PER_W-1:0] tbl_zero [N];

  for (genvar g = 0; g < N; g++) begin : g_tbl
    assign tbl_one[g]  = PER_W'((PMIN + g + 1) / 3);
    assign tbl_zero[g] = PER_W'((2 * (PMIN + g) + 1) / 3);
  end

  int idx;

  always_comb begin
    idx = int'(period_i) - PMIN;
    if (idx >= 0 && idx < N)
      low_o = bit_i ? tbl_one[idx] : tbl_zero[idx];
    else
      low_o = bit_i ? PER_W'((NOM + 1) / 3) : PER_W'((2 * NOM + 1) / 3);
  end

endmodule

// File: rtl/pwm_bus_encoder.sv
module pwm_bus_encoder
  import pwm_enc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 6,
  parameter int PER_W  = 6,
  parameter int NOM    = 30,
  parameter int MINP   = 27,
  parameter int DEV_HI = 4,
  parameter int DEV_LO = 2,
  parameter int LFSR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  frame_len_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        dev_sel_i,
  output logic              bus_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int IDX_W = $clog2(DATA_W);

  enc_state_t        state_q, state_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic [IDX_W-1:0]  idx_q, idx_d, idx_first, idx_dec;
  logic [PER_W-1:0]  cnt_q, cnt_d, per_q, per_d, low_q, low_d;
  logic [PER_W-1:0]  gen_per, low_nx;
  logic [LEN_W-1:0]  len_eff;
  logic              load_first, bit_end, next_bit;
  logic              reg_en;

  assign reg_en = 1'b1;

  pwm_dither_gen #(
    .LFSR_W (LFSR_W),
    .TAPS   (LFSR_W'(16'hB400)),
    .SEED   (LFSR_W'(16'hACE1)),
    .PER_W  (PER_W),
    .NOM    (NOM),
    .MINP   (MINP),
    .DEV_HI (DEV_HI),
    .DEV_LO (DEV_LO)
  ) u_dither (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_sel_i (dev_sel_i),
    .period_o  (gen_per)
  );

  pwm_phase_lut #(
    .PER_W (PER_W),
    .PMIN  (NOM - DEV_HI),
    .PMAX  (NOM + DEV_HI),
    .NOM   (NOM)
  ) u_lut (
    .period_i (gen_per),
    .bit_i    (next_bit),
    .low_o    (low_nx)
  );

  always_comb begin
    if (frame_len_i == '0)                      len_eff = LEN_W'(1);
    else if (frame_len_i > LEN_W'(DATA_W))      len_eff = LEN_W'(DATA_W);
    else                                        len_eff = frame_len_i;
    idx_first  = IDX_W'(len_eff - LEN_W'(1));
    idx_dec    = idx_q - IDX_W'(1);
    load_first = (state_q == ST_IDLE) && start_i;
    bit_end    = (state_q == ST_BIT) && (cnt_q == per_q - PER_W'(1));
    next_bit   = load_first ? data_i[idx_first] : data_q[idx_dec];
  end

  always_comb begin
    state_d = state_q;
    data_d  = data_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    per_d   = per_q;
    low_d   = low_q;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_BIT;
          data_d  = data_i;
          idx_d   = idx_first;
          cnt_d   = '0;
          per_d   = gen_per;
          low_d   = low_nx;
        end
      end
      ST_BIT: begin
        if (bit_end) begin
          if (idx_q == '0) begin
            state_d = ST_DONE;
          end else begin
            idx_d = idx_dec;
            cnt_d = '0;
            per_d = gen_per;
            low_d = low_nx;
          end
        end else begin
          cnt_d = cnt_q + PER_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      per_q   <= PER_W'(NOM);
      low_q   <= '0;
    end else if (reg_en) begin
      state_q <= state_d;
      data_q  <= data_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      per_q   <= per_d;
      low_q   <= low_d;
    end
  end

  assign bus_o  = !((state_q == ST_BIT) && (cnt_q < low_q));
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_DONE);

  // R10: done lasts a single clock
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10: the line rests high whenever no frame is in flight
  assert_idle_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> bus_o);

  // R9: a strobe while busy leaves the captured word untouched
  assert_ignore_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(data_q));

  // R6: every latched bit period respects the floor and ceiling
  assert_period_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BIT) |-> ((int'(per_q) >= MINP) && (int'(per_q) <= NOM + DEV_HI)));

  // R2: the bit counter never runs past its period
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BIT) |-> (cnt_q < per_q));

endmodule

// File: tb/tb_pwm_bus_encoder.sv
module tb_pwm_bus_encoder;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [5:0]  frame_len;
  logic [31:0] data;
  logic [1:0]  dev;
  logic        bus, busy, done;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  int inj_at = -1;
  int cycles = 0;

  pwm_bus_encoder dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .frame_len_i (frame_len),
    .data_i      (data),
    .dev_sel_i   (dev),
    .bus_o       (bus),
    .busy_o      (busy),
    .done_o      (done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {len[5:0], dev[1:0], data[31:0]}
  localparam logic [39:0] VECS [0:6] = '{
    {6'd32, 2'b00, 32'hA5C3_0F81},
    {6'd8,  2'b11, 32'h0000_00B4},
    {6'd32, 2'b10, 32'hFFFF_0000},
    {6'd32, 2'b01, 32'h1234_5678},
    {6'd1,  2'b00, 32'h0000_0001},
    {6'd16, 2'b01, 32'h0000_F0F0},
    {6'd5,  2'b10, 32'h0000_0015}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        miscompares++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        finish_run();
      end
    end
  end

  task automatic step();
    @(negedge clk);
    cyc++;
    if (cyc == inj_at) begin
      start = 1'b1;
      data  = ~data;
    end else if (cyc == inj_at + 1) begin
      start = 1'b0;
    end
  endtask

  task automatic run_frame(input logic [5:0] len, input logic [31:0] d,
                           input logic [1:0] dv, input int inject_mid,
                           input bit inject_done);
    int eff, nb, lo, hi, pmin, pmax, plo, phi, explo;
    int lows [0:39];
    int pers [0:39];
    bit expb, gotb;
    string rtag;
    eff = (len == 0) ? 1 : (len > 32) ? 32 : int'(len);
    @(negedge clk);
    frame_len = len; data = d; dev = dv; start = 1'b1;
    cyc = 0; inj_at = inject_mid;
    step();
    start = 1'b0;
    check(busy == 1'b1, "R10 busy after start", int'(busy), 1);
    nb = 0;
    while (1) begin
      lo = 0;
      while (bus == 1'b0 && lo < 100) begin lo++; step(); end
      hi = 0;
      while (bus == 1'b1 && !done && hi < 100) begin hi++; step(); end
      lows[nb] = lo; pers[nb] = lo + hi; nb++;
      if (done || nb >= 40 || lo >= 100 || hi >= 100) break;
    end
    check(done == 1'b1, "R10 done after last high phase", int'(done), 1);
    if (inject_done) begin start = 1'b1; data = ~d; end
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0 && busy == 1'b0 && bus == 1'b1, "R10 R9 idle after done",
          int'({done, busy, bus}), 1);
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R9 no frame restarted", int'(busy), 0);
    check(nb == eff, "R8 bit count", nb, eff);
    case (dv)
      2'b01:   begin plo = 27; phi = 34; rtag = "R6 period window"; end
      2'b10:   begin plo = 28; phi = 32; rtag = "R5 period window"; end
      default: begin plo = 30; phi = 30; rtag = "R4 fixed period"; end
    endcase
    pmin = 1000; pmax = 0;
    for (int k = 0; k < nb && k < eff; k++) begin
      expb  = d[eff-1-k];
      gotb  = (2 * lows[k] < pers[k]);
      check(gotb == expb, "R7 bit order/value", int'(gotb), int'(expb));
      check(pers[k] >= plo && pers[k] <= phi, rtag, pers[k], plo);
      explo = expb ? (pers[k] + 1) / 3 : (2 * pers[k] + 1) / 3;
      check(lows[k] == explo, expb ? "R3 one low phase" : "R2 zero low phase",
            lows[k], explo);
      if (pers[k] < pmin) pmin = pers[k];
      if (pers[k] > pmax) pmax = pers[k];
    end
    if (dv == 2'b01 && eff >= 16)
      check(pmax != pmin, "R6 period varies", pmax, pmin);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; frame_len = 6'd8; data = '0; dev = 2'b00;
    repeat (3) @(negedge clk);
    check(bus == 1'b1 && busy == 1'b0 && done == 1'b0, "R1 reset state",
          int'({bus, busy, done}), 4);
    rst_n = 1'b1;
    @(negedge clk);
    check(bus == 1'b1 && busy == 1'b0 && done == 1'b0, "R1 after release",
          int'({bus, busy, done}), 4);

    for (int v = 0; v < 7; v++)
      run_frame(VECS[v][39:34], VECS[v][31:0], VECS[v][33:32], -1, 1'b0);

    // R8: out-of-range lengths
    run_frame(6'd0,  32'hFFFF_FFFF, 2'b00, -1, 1'b0);
    run_frame(6'd40, 32'hC0FF_EE01, 2'b10, -1, 1'b0);

    // R9: strobes mid-frame and in the done cycle
    run_frame(6'd12, 32'h0000_0A5C, 2'b01, 40, 1'b1);
    run_frame(6'd3,  32'h0000_0006, 2'b00, 5, 1'b1);

    // R1: reset in the middle of a frame
    @(negedge clk);
    frame_len = 6'd8; data = 32'h0; dev = 2'b00; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(bus == 1'b0, "R1 frame running before reset", int'(bus), 0);
    #1 rst_n = 1'b0;
    #1 check(bus == 1'b1 && busy == 1'b0, "R1 reset mid-frame", int'({bus, busy}), 2);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(bus == 1'b1 && busy == 1'b0 && done == 1'b0, "R1 idle after reset",
          int'({bus, busy, done}), 4);

    finish_run();
  end

endmodule